// File: doc/BRIEF.md
# Infrared pulse run-length encoder

This block takes the demodulated output of an infrared receiver and turns it into a stream of one-byte run-length codes. Each code gives the level the line held and how many sample periods that level lasted. A prescaler derives a sample tick from the module clock. The sampled input can be inverted, so that an active-low receiver still reports its bursts as pulses. Level changes that do not persist past a programmable noise threshold are treated as glitches and absorbed into the ongoing run.

A packet opens when the first pulse is accepted. It closes when the line has held the space level for a programmable number of 128-sample blocks. At that point the block emits the final space code together with a one-cycle packet-end strobe. It then stays silent until the next accepted pulse. Storage of the codes, the register interface and interrupt generation are left to the surrounding logic.

Top module: `ir_rle_enc`

## Requirements
- R1: While `rxEnable` is high, one sample is taken every `SAMPLE_DIV` clocks. The first sample is taken on the `SAMPLE_DIV`-th rising edge after enable is seen high. The input passes through a two-flop synchronizer before sampling.
- R2: A code byte holds the level in bit 7 (1 = pulse, 0 = space) and the run length in samples minus one in bits 6:0. A run of N samples is reported as N-1.
- R3: When `invert` is 1, the synchronized input is complemented before it is sampled.
- R4: A change of level is accepted only on the sample where the differing level has been seen for `noiseThr`+1 consecutive samples. Differing samples before that one are counted into the old run. The new run starts with the accepting sample. With `noiseThr` = 0, every change is accepted at once.
- R5: A run longer than 128 samples is split. On its 129th sample a code with length field 127 is emitted, and that sample starts a new code of the same level.
- R6: The idle count starts at the sample where a space is accepted. Once (`idleThr`+1)×128 space samples have been counted, `packetEnd` pulses for one cycle together with `codeValid`, carrying the final space code. Packet end occurs once per idle period.
- R7: No code is emitted between packet end and the next accepted pulse. The accepting sample opens the packet without emitting anything, so the leading space is not reported.
- R8: While `rxEnable` is low, the prescaler, noise filter, run counter, idle counter and packet state are held cleared, and no code is emitted.
- R9: During and right after reset, `codeValid`, `packetEnd` and `codeData` are 0.
- R10: `codeValid`, `codeData` and `packetEnd` are registered. They change on the clock edge that follows the edge on which the sample was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receive enable; low clears all counters |
| invert | input | 1 | Complement the input before sampling |
| noiseThr | input | NOISE_W (6) | Glitch length, in samples, that is filtered |
| idleThr | input | IDLE_W (8) | Idle timeout in 128-sample blocks, minus one |
| irIn | input | 1 | Demodulated receiver output, asynchronous |
| codeValid | output | 1 | Code strobe, one cycle |
| codeData | output | LEN_W+1 (8) | Level in the top bit, length minus one below it |
| packetEnd | output | 1 | One-cycle end-of-packet strobe, coincident with the last code |

## Verification
The bench targets three areas: glitches of exactly `noiseThr` samples and of one sample more, runs that cross the 128-sample split, and idle periods that reach the timeout exactly.

- **Glitch length:** a design that counted the wrong number of samples would swallow real edges or leak glitches. A design that charged the pending samples to the wrong run would shift a length by the threshold.
- **Split boundary:** an off-by-one at the split would emit 128-sample codes with length field 0 or 126.
- **Idle timeout:** a timeout not scaled by 128, or not restarted at the space edge, would end packets early or late. A timeout that fired again during the same idle period would emit a second packet-end.

The bench also drops the enable in the middle of a pulse. A design that kept its run counter across the gap would report a longer pulse afterwards.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;

  // Per-sample decisions handed from the control to the datapath.
  typedef struct packed {
    logic tick;      // a sample is taken this cycle
    logic inPkt;     // a packet was open before this sample
    logic level;     // committed level before this sample
    logic startPkt;  // accepted pulse opens a packet
    logic levelChg;  // accepted level change inside a packet
    logic pktEnd;    // idle timeout reached on this sample
  } rleStrobe_t;

endpackage

// File: rtl/ir_rle_sync.sv
module ir_rle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ir_rle_ctrl.sv
module ir_rle_ctrl
  import ir_rle_pkg::*;
#(
  parameter int SAMPLE_DIV = 64,
  parameter int NOISE_W    = 6,
  parameter int IDLE_W     = 8,
  parameter int IDLE_SHIFT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxEnable,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  input  logic               lineSync,
  output rleStrobe_t         strobe
);

  localparam int DIV_W      = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int IDLE_CNT_W = IDLE_W + IDLE_SHIFT + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

  logic [DIV_W-1:0]      divCnt;
  logic                  level;
  logic [NOISE_W-1:0]    pendCnt;
  logic                  inPkt;
  logic [IDLE_CNT_W-1:0] idleCnt;

  logic                  tickNow;
  logic                  sample;
  logic                  differs;
  logic                  accept;
  logic                  nextLevel;
  logic [IDLE_CNT_W-1:0] idleLimit;
  logic [IDLE_CNT_W-1:0] idleNext;
  logic                  startNow;
  logic                  chgNow;
  logic                  pktEndNow;

  always_comb begin
    tickNow   = rxEnable && (divCnt == DIV_LAST);
    sample    = lineSync ^ invert;
    differs   = (sample != level);
    accept    = tickNow && differs && (pendCnt >= noiseThr);
    nextLevel = accept ? sample : level;
    idleLimit = (IDLE_CNT_W'(idleThr) + IDLE_CNT_W'(1)) << IDLE_SHIFT;
    idleNext  = nextLevel ? '0 : idleCnt + IDLE_CNT_W'(1);
    startNow  = accept && !inPkt;
    chgNow    = accept && inPkt;
    pktEndNow = tickNow && inPkt && !nextLevel && (idleNext >= idleLimit);
  end

  always_comb begin
    strobe.tick     = tickNow;
    strobe.inPkt    = inPkt;
    strobe.level    = level;
    strobe.startPkt = startNow;
    strobe.levelChg = chgNow;
    strobe.pktEnd   = pktEndNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      level   <= 1'b0;
      pendCnt <= '0;
      inPkt   <= 1'b0;
      idleCnt <= '0;
    end else if (!rxEnable) begin
      divCnt  <= '0;
      level   <= 1'b0;
      pendCnt <= '0;
      inPkt   <= 1'b0;
      idleCnt <= '0;
    end else begin
      divCnt <= tickNow ? '0 : divCnt + DIV_W'(1);
      if (tickNow) begin
        if (pktEndNow || !differs || accept) pendCnt <= '0;
        else                                 pendCnt <= pendCnt + NOISE_W'(1);
        level <= pktEndNow ? 1'b0 : nextLevel;
        if (startNow) begin
          inPkt   <= 1'b1;
          idleCnt <= '0;
        end else if (pktEndNow) begin
          inPkt   <= 1'b0;
          idleCnt <= '0;
        end else if (inPkt) begin
          idleCnt <= idleNext;
        end
      end
    end
  end

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (divCnt == '0) && !inPkt && (idleCnt == '0) && (pendCnt == '0));

  // R6
  pkt_end_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktEndNow |=> !inPkt && !level);

  // R7
  one_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startNow, chgNow, pktEndNow}));

  // R7
  start_is_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> inPkt && level);

  generate
    if (SAMPLE_DIV > 1) begin : g_spacing
      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
        tickNow |=> !tickNow);
    end
  endgenerate

endmodule

// File: rtl/ir_rle_dp.sv
module ir_rle_dp
  import ir_rle_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  rleStrobe_t       st,
  output logic             codeValid,
  output logic [LEN_W:0]   codeData,
  output logic             packetEnd
);

  localparam logic [LEN_W-1:0] RUN_MAX = '1;

  logic [LEN_W-1:0] runCnt;
  logic [LEN_W-1:0] lastLen;

  // Length of the closing space code; saturates if the timeout coincides with a split.
  assign lastLen = (runCnt == RUN_MAX) ? RUN_MAX : runCnt + LEN_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      codeValid <= 1'b0;
      codeData  <= '0;
      packetEnd <= 1'b0;
    end else begin
      codeValid <= 1'b0;
      packetEnd <= 1'b0;
      if (!rxEnable) begin
        runCnt <= '0;
      end else if (st.tick) begin
        if (st.startPkt) begin
          runCnt <= '0;
        end else if (st.inPkt) begin
          if (st.pktEnd) begin
            codeValid <= 1'b1;
            packetEnd <= 1'b1;
            codeData  <= {1'b0, lastLen};
            runCnt    <= '0;
          end else if (st.levelChg) begin
            codeValid <= 1'b1;
            codeData  <= {st.level, runCnt};
            runCnt    <= '0;
          end else if (runCnt == RUN_MAX) begin
            codeValid <= 1'b1;
            codeData  <= {st.level, RUN_MAX};
            runCnt    <= '0;
          end else begin
            runCnt <= runCnt + LEN_W'(1);
          end
        end
      end
    end
  end

  // R10
  code_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> $past(st.tick));

  // R6
  end_with_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    packetEnd |-> codeValid && !codeData[LEN_W]);

  // R7
  codes_in_pkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> $past(st.inPkt));

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !codeValid && (runCnt == '0));

endmodule

// File: rtl/ir_rle_enc.sv
module ir_rle_enc
  import ir_rle_pkg::*;
#(
  parameter int SAMPLE_DIV  = 64,
  parameter int LEN_W       = 7,
  parameter int NOISE_W     = 6,
  parameter int IDLE_W      = 8,
  parameter int IDLE_SHIFT  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxEnable,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  input  logic               irIn,
  output logic               codeValid,
  output logic [LEN_W:0]     codeData,
  output logic               packetEnd
);

  logic       lineSync;
  rleStrobe_t strobe;

  ir_rle_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (irIn),
    .dout (lineSync)
  );

  ir_rle_ctrl #(
    .SAMPLE_DIV (SAMPLE_DIV),
    .NOISE_W    (NOISE_W),
    .IDLE_W     (IDLE_W),
    .IDLE_SHIFT (IDLE_SHIFT)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxEnable (rxEnable),
    .invert   (invert),
    .noiseThr (noiseThr),
    .idleThr  (idleThr),
    .lineSync (lineSync),
    .strobe   (strobe)
  );

  ir_rle_dp #(.LEN_W(LEN_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnable  (rxEnable),
    .st        (strobe),
    .codeValid (codeValid),
    .codeData  (codeData),
    .packetEnd (packetEnd)
  );

endmodule

// File: tb/sim_ir_rle_enc.sv
module sim_ir_rle_enc;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rxEnable;
  logic       invert;
  logic [5:0] noiseThr;
  logic [7:0] idleThr;
  logic       irIn;
  logic       codeValid;
  logic [7:0] codeData;
  logic       packetEnd;

  always #4 clk = ~clk;

  ir_rle_enc #(.SAMPLE_DIV(DIV)) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnable  (rxEnable),
    .invert    (invert),
    .noiseThr  (noiseThr),
    .idleThr   (idleThr),
    .irIn      (irIn),
    .codeValid (codeValid),
    .codeData  (codeData),
    .packetEnd (packetEnd)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model, evaluated on every rising edge.
  int mS1, mS2, mDiv, mLvl, mPend, mInP, mIdle, mRun;
  bit eV, eE;
  int eD;

  always @(posedge clk) begin : model
    int smp, old, acc, lim;
    eV = 0;
    eE = 0;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mDiv = 0; mLvl = 0; mPend = 0; mInP = 0; mIdle = 0; mRun = 0;
      eD = 0;
    end else begin
      smp = mS2 ^ int'(invert);
      mS2 = mS1;
      mS1 = int'(irIn);
      if (!rxEnable) begin
        mDiv = 0; mLvl = 0; mPend = 0; mInP = 0; mIdle = 0; mRun = 0;
      end else if (mDiv == DIV - 1) begin
        mDiv = 0;
        old = mLvl;
        acc = 0;
        if (smp != mLvl) begin
          if (mPend >= int'(noiseThr)) begin
            acc = 1; mLvl = smp; mPend = 0;
          end else mPend++;
        end else mPend = 0;
        if (mInP == 0) begin
          if (acc == 1) begin mInP = 1; mRun = 0; mIdle = 0; end
        end else begin
          if (mLvl == 1) mIdle = 0; else mIdle++;
          lim = (int'(idleThr) + 1) * 128;
          if (mLvl == 0 && mIdle >= lim) begin
            eV = 1; eE = 1; eD = (mRun == 127) ? 127 : mRun + 1;
            mInP = 0; mIdle = 0; mPend = 0; mRun = 0; mLvl = 0;
          end else if (acc == 1) begin
            eV = 1; eD = old * 128 + mRun; mRun = 0;
          end else if (mRun == 127) begin
            eV = 1; eD = mLvl * 128 + 127; mRun = 0;
          end else mRun++;
        end
      end else mDiv++;
    end
  end

  // Cycle compare against the model, plus code capture for directed checks.
  int gotQ[$];
  int expQ[$];
  int peCnt = 0;
  int peIdx = -1;

  always @(negedge clk) begin
    if (rstN && (eV || eE || codeValid || packetEnd)) begin
      chk((codeValid == eV) && (packetEnd == eE) && (!eV || codeData == eD[7:0]),
          (eE || packetEnd) ? "R6 model" : ((eD % 128) == 127 ? "R5 model" : "R1/R10 model"),
          {packetEnd, codeValid, codeData}, {eE, eV, eD[7:0]});
    end
    if (rstN && codeValid) begin
      if (packetEnd) begin peCnt++; peIdx = gotQ.size(); end
      gotQ.push_back(int'(codeData));
    end
  end

  bit invLine = 1'b0;

  task automatic hold(input bit lvl, input int n);
    irIn = lvl ^ invLine;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic clearCapture();
    gotQ.delete();
    peCnt = 0;
    peIdx = -1;
  endtask

  task automatic expectCodes(input string req, input int expPe);
    chk(gotQ.size() == expQ.size(), {req, " code count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < gotQ.size() && i < expQ.size(); i++)
      chk(gotQ[i] == expQ[i], {req, " code byte"}, gotQ[i], expQ[i]);
    chk(peCnt == expPe, {req, " packet end count"}, peCnt, expPe);
    if (expPe > 0)
      chk(peIdx == expQ.size() - 1, {req, " packet end on last code"}, peIdx, expQ.size() - 1);
    clearCapture();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    bit seen;
    rstN = 1'b0; rxEnable = 1'b0; invert = 1'b0; noiseThr = 6'd0; idleThr = 8'd0; irIn = 1'b0;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(codeValid == 0 && packetEnd == 0 && codeData == 0, "R9 in reset",
        {packetEnd, codeValid, codeData}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(codeValid == 0 && packetEnd == 0 && codeData == 0, "R9 after reset",
        {packetEnd, codeValid, codeData}, 0);
    rxEnable = 1'b1;
    hold(0, 20);
    clearCapture();

    // R2: plain pulses, level in bit 7, length minus one below
    hold(1, 10); hold(0, 5); hold(1, 3); hold(0, 150);
    expQ = {8'h89, 8'h04, 8'h82, 8'h7F};
    expectCodes("R2", 1);

    // R3: inverted line with invert set gives the same codes
    invert = 1'b1; invLine = 1'b1;
    hold(0, 20);
    clearCapture();
    hold(1, 10); hold(0, 5); hold(1, 3); hold(0, 150);
    expQ = {8'h89, 8'h04, 8'h82, 8'h7F};
    expectCodes("R3", 1);
    invert = 1'b0; invLine = 1'b0;
    hold(0, 20);
    clearCapture();

    // R4: glitch of exactly noiseThr samples is absorbed
    noiseThr = 6'd2;
    hold(1, 10); hold(0, 2); hold(1, 10); hold(0, 150);
    expQ = {8'h95, 8'h7F};
    expectCodes("R4 glitch absorbed", 1);

    // R4: one sample longer than noiseThr is a real edge
    hold(1, 10); hold(0, 3); hold(1, 10); hold(0, 150);
    expQ = {8'h89, 8'h02, 8'h89, 8'h7F};
    expectCodes("R4 edge accepted", 1);
    noiseThr = 6'd0;

    // R5: a 300-sample pulse is split into 128 + 128 + 44
    hold(1, 300); hold(0, 150);
    expQ = {8'hFF, 8'hFF, 8'hAB, 8'h7F};
    expectCodes("R5", 1);

    // R7: silence after packet end
    hold(0, 300);
    expQ.delete();
    expectCodes("R7", 0);

    // R6: idle threshold scaled by 128 samples, single packet end
    idleThr = 8'd1;
    hold(1, 5); hold(0, 280);
    expQ = {8'h84, 8'h7F, 8'h7F};
    expectCodes("R6", 1);
    idleThr = 8'd0;

    // R8: dropping the enable mid-pulse clears the run
    hold(1, 50);
    rxEnable = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (codeValid || packetEnd) seen = 1'b1;
    end
    chk(!seen, "R8 quiet while disabled", seen, 0);
    rxEnable = 1'b1;
    hold(1, 20); hold(0, 150);
    expQ = {8'h93, 8'h7F};
    expectCodes("R8 restart", 1);

    // Random patterns against the cycle model (R1 R4 R5 R6 R10)
    for (int k = 0; k < 24; k++) begin
      noiseThr = 6'($urandom_range(0, 3));
      idleThr  = 8'($urandom_range(0, 1));
      invert   = 1'($urandom_range(0, 1));
      invLine  = invert;
      for (int s = 0; s < 10; s++) begin
        irIn = (s % 2 == 0) ^ invLine;
        repeat ($urandom_range(1, 70)) @(negedge clk);
        if (k == 7 && s == 4) begin
          rxEnable = 1'b0;
          repeat ($urandom_range(1, 9)) @(negedge clk);
          rxEnable = 1'b1;
        end
      end
      hold(0, (int'(idleThr) + 1) * 128 + 12);
    end
    clearCapture();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule